// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors run side by side. The first looks up a per-branch history, selected by PC bits, and uses that history to pick a 3-bit counter. The second uses a shift register of recent branch directions across all branches to pick a 2-bit counter. A table of 2-bit selector counters, indexed by the same global history, decides which of the two component guesses is used.

A lookup is combinational. The front end presents a PC and, in the same cycle, receives the direction and a copy of the global history as it stood before this guess. When `pred_valid` is high, the guessed direction is shifted into the global history at the next edge. When the branch resolves, the back end returns the PC, the real direction, a mispredict flag and the saved history copy. The tables are trained at that point. On a mispredict, the global history is rebuilt from the saved copy with the real direction appended.

Top module: `tbp_predictor`

## Requirements
- R1: After reset, every counter, every per-branch history and the global history are zero. Every lookup then returns not-taken, with a history copy of zero.
- R2: The direction is the MSB of the global counter when the MSB of the selector counter is 1. Otherwise it is the MSB of the local counter. The selector and global counters are indexed by the global history. The local counter is indexed by the per-branch history at entry `pc[PC_LSB +: LHT_IDX_W]`.
- R3: `pred_ghist` shows the global history before the current lookup's shift, in the same cycle as the lookup.
- R4: When `pred_valid` is high and no mispredict is being resolved, the global history becomes `{ghist[GHIST_W-2:0], pred_taken}` at the next edge. The newest direction is in bit 0.
- R5: A resolve with `res_mispredict` high sets the global history to `{res_ghist[GHIST_W-2:0], res_taken}`. This takes priority over a lookup in the same cycle.
- R6: A per-branch history changes only at resolve. The real direction is shifted into its bit 0. A lookup leaves it unchanged.
- R7: At resolve, the 3-bit local counter chosen by the per-branch history before its update moves up on taken and down on not-taken. It saturates at 0 and at 7.
- R8: At resolve, the 2-bit global counter at index `res_ghist` moves up on taken and down on not-taken. It saturates at 0 and at 3.
- R9: The selector counter at `res_ghist` is trained only when the local and global MSBs disagree. These MSBs are read at resolve, before the update. The counter moves up when the global guess was right and down when it was wrong, and it saturates at both ends.
- R10: With no lookup and no mispredict, the global history holds its value. A resolve without a mispredict does not change it.
- R11: A lookup in the same cycle as a resolve reads the table contents from before that resolve's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid | input | 1 | Lookup is real; shift its guess into the global history |
| pred_pc | input | PC_W | PC of the branch being looked up |
| pred_taken | output | 1 | Guessed direction |
| pred_ghist | output | GHIST_W | Global history before this guess |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | PC of the resolving branch |
| res_taken | input | 1 | Real direction |
| res_mispredict | input | 1 | The earlier guess was wrong |
| res_ghist | input | GHIST_W | History copy saved at lookup |

## Verification
A lookup and a resolve can fall in the same cycle. They may both touch the global history, and they may touch the same counters. The bench provokes this by resolving and looking up the same PC in one cycle, both with and without the mispredict flag. The lookup must reflect the tables from before the edge. After the edge, the history must show either the repaired value or the speculative shift, as R5 and R11 require. A long pseudo-random sweep over a small configuration mixes both ports every cycle. It compares every output against an arithmetic model of all the tables.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  // Saturating step of a counter of width w (w <= 8).
  function automatic logic [7:0] sat_step(input logic [7:0] cur, input logic up, input int w);
    logic [7:0] top;
    top = 8'((1 << w) - 1);
    if (up) return (cur == top) ? cur : cur + 8'd1;
    else    return (cur == 8'd0) ? cur : cur - 8'd1;
  endfunction
endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
  parameter int IDX_W = 12,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_msb,
  input  logic [IDX_W-1:0] trn_idx,
  input  logic             trn_en,
  input  logic             trn_up,
  output logic             trn_msb
);
  import tbp_pkg::*;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] TOP = {CTR_W{1'b1}};

  logic [CTR_W-1:0] mem [DEPTH];
  logic [CTR_W-1:0] trn_cur, trn_next;

  assign rd_msb  = mem[rd_idx][CTR_W-1];
  assign trn_cur = mem[trn_idx];
  assign trn_msb = trn_cur[CTR_W-1];
  assign trn_next = CTR_W'(sat_step(8'(trn_cur), trn_up, CTR_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (trn_en) begin
      mem[trn_idx] <= trn_next;
    end
  end

  // R7 R8 R9
  ceiling_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_en && trn_up && trn_cur == TOP) |=> mem[$past(trn_idx)] == TOP);
  // R7 R8 R9
  floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_en && !trn_up && trn_cur == '0) |=> mem[$past(trn_idx)] == '0);
  // R9
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trn_en |=> mem[$past(trn_idx)] == $past(trn_cur));
endmodule

// File: rtl/tbp_local_hist.sv
module tbp_local_hist #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic              upd_en,
  input  logic              upd_taken,
  output logic [HIST_W-1:0] upd_hist
);
  localparam int DEPTH = 1 << IDX_W;
  logic [HIST_W-1:0] mem [DEPTH];

  assign rd_hist  = mem[rd_idx];
  assign upd_hist = mem[upd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (upd_en) begin
      mem[upd_idx] <= {upd_hist[HIST_W-2:0], upd_taken};
    end
  end

  // R6
  newest_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> mem[$past(upd_idx)][0] == $past(upd_taken));
  // R6
  no_spec_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> mem[$past(upd_idx)] == $past(upd_hist));
endmodule

// File: rtl/tbp_ghist.sv
module tbp_ghist #(
  parameter int GHIST_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spec_en,
  input  logic               spec_bit,
  input  logic               fix_en,
  input  logic [GHIST_W-1:0] fix_snap,
  input  logic               fix_bit,
  output logic [GHIST_W-1:0] hist
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist <= '0;
    else if (fix_en)  hist <= {fix_snap[GHIST_W-2:0], fix_bit};
    else if (spec_en) hist <= {hist[GHIST_W-2:0], spec_bit};
  end

  // R5
  repair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_en |=> (hist[0] == $past(fix_bit)) && (hist[GHIST_W-1:1] == $past(fix_snap[GHIST_W-2:0])));
  // R4
  spec_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_en && !fix_en) |=> (hist[0] == $past(spec_bit)) && (hist[GHIST_W-1:1] == $past(hist[GHIST_W-2:0])));
endmodule

// File: rtl/tbp_predictor.sv
module tbp_predictor #(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int LHT_IDX_W = 10,
  parameter int LHIST_W   = 10,
  parameter int LCTR_W    = 3,
  parameter int GHIST_W   = 12,
  parameter int GCTR_W    = 2,
  parameter int CCTR_W    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pred_valid,
  input  logic [PC_W-1:0]    pred_pc,
  output logic               pred_taken,
  output logic [GHIST_W-1:0] pred_ghist,
  input  logic               res_valid,
  input  logic [PC_W-1:0]    res_pc,
  input  logic               res_taken,
  input  logic               res_mispredict,
  input  logic [GHIST_W-1:0] res_ghist
);
  logic [LHT_IDX_W-1:0] pred_lidx, res_lidx;
  logic [LHIST_W-1:0]   pred_lhist, res_lhist;
  logic [GHIST_W-1:0]   ghist;
  logic pred_lmsb, pred_gmsb, pred_sel_global;
  logic res_lpred, res_gpred, res_csel_unused;
  logic res_disagree, res_global_right, repair_now;
  logic unused_pc_bits;

  assign pred_lidx = pred_pc[PC_LSB +: LHT_IDX_W];
  assign res_lidx  = res_pc[PC_LSB +: LHT_IDX_W];
  assign unused_pc_bits = ^{pred_pc, res_pc};

  assign res_disagree     = res_lpred != res_gpred;
  assign res_global_right = res_gpred == res_taken;
  assign repair_now       = res_valid && res_mispredict;

  tbp_local_hist #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(pred_lidx), .rd_hist(pred_lhist),
    .upd_idx(res_lidx), .upd_en(res_valid), .upd_taken(res_taken),
    .upd_hist(res_lhist));

  tbp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) u_lctr (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(pred_lhist), .rd_msb(pred_lmsb),
    .trn_idx(res_lhist), .trn_en(res_valid), .trn_up(res_taken),
    .trn_msb(res_lpred));

  tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) u_gctr (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghist), .rd_msb(pred_gmsb),
    .trn_idx(res_ghist), .trn_en(res_valid), .trn_up(res_taken),
    .trn_msb(res_gpred));

  tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(CCTR_W)) u_choice (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghist), .rd_msb(pred_sel_global),
    .trn_idx(res_ghist), .trn_en(res_valid && res_disagree), .trn_up(res_global_right),
    .trn_msb(res_csel_unused));

  tbp_ghist #(.GHIST_W(GHIST_W)) u_ghist (
    .clk(clk), .rst_n(rst_n),
    .spec_en(pred_valid), .spec_bit(pred_taken),
    .fix_en(repair_now), .fix_snap(res_ghist), .fix_bit(res_taken),
    .hist(ghist));

  assign pred_taken = pred_sel_global ? pred_gmsb : pred_lmsb;
  assign pred_ghist = ghist;

  // R3
  snapshot_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !repair_now) |=> pred_ghist[0] == $past(pred_taken));
  // R10
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pred_valid && !repair_now) |=> $stable(pred_ghist));
endmodule

// File: tb/tbp_predictor_bench.sv
`timescale 1ns/1ps
module tbp_predictor_bench;
  localparam int PW = 16, LI = 3, LH = 3, G = 4;
  logic clk = 0, rst_n = 0;
  logic pv = 0, rv = 0, rt = 0, rm = 0;
  logic [PW-1:0] ppc = '0, rpc = '0;
  logic [G-1:0] rg = '0;
  logic pt;
  logic [G-1:0] pg;
  int tests = 0, fails = 0;
  bit done = 0;

  // model state
  int m_lht[8], m_lc[8], m_gc[16], m_cc[16], m_gh;

  always #10 clk = ~clk;

  tbp_predictor #(.PC_W(PW), .PC_LSB(2), .LHT_IDX_W(LI), .LHIST_W(LH), .LCTR_W(3),
                  .GHIST_W(G), .GCTR_W(2), .CCTR_W(2)) u_tbp_predictor (
    .clk(clk), .rst_n(rst_n), .pred_valid(pv), .pred_pc(ppc), .pred_taken(pt),
    .pred_ghist(pg), .res_valid(rv), .res_pc(rpc), .res_taken(rt),
    .res_mispredict(rm), .res_ghist(rg));

  function automatic int mv(int c, bit up, int top);
    if (up) return (c >= top) ? top : c + 1;
    return (c <= 0) ? 0 : c - 1;
  endfunction

  function automatic bit m_pred(int pc);
    int li, l, g, c;
    li = (pc / 4) % 8;
    l = m_lc[m_lht[li]] / 4;
    g = m_gc[m_gh] / 2;
    c = m_cc[m_gh] / 2;
    return (c != 0) ? bit'(g) : bit'(l);
  endfunction

  task automatic chk(string tag, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit ipv, int ippc, bit irv, int irpc, bit irt, bit irm, int irg, string tag);
    bit et;
    int li, lh, lp, gp;
    @(negedge clk);
    pv = ipv; ppc = PW'(ippc); rv = irv; rpc = PW'(irpc); rt = irt; rm = irm; rg = G'(irg);
    #1;
    et = m_pred(ippc);
    chk(tag, int'(pt), int'(et), "direction");
    chk(tag, int'(pg), m_gh, "history copy");
    if (irv) begin
      li = (irpc / 4) % 8;
      lh = m_lht[li];
      lp = m_lc[lh] / 4;
      gp = m_gc[irg] / 2;
      m_lc[lh] = mv(m_lc[lh], irt, 7);
      m_gc[irg] = mv(m_gc[irg], irt, 3);
      if (lp != gp) m_cc[irg] = mv(m_cc[irg], (gp == int'(irt)), 3);
      m_lht[li] = ((lh * 2) + int'(irt)) % 8;
    end
    if (irv && irm) m_gh = ((irg * 2) + int'(irt)) % 16;
    else if (ipv) m_gh = ((m_gh * 2) + int'(et)) % 16;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 8; i++) begin m_lht[i] = 0; m_lc[i] = 0; end
    for (int i = 0; i < 16; i++) begin m_gc[i] = 0; m_cc[i] = 0; end
    m_gh = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1: reset state, all entries not-taken with zero history
    for (int p = 0; p < 8; p++) step(0, p * 4, 0, 0, 0, 0, 0, "R1");
    // R4: speculative shifts of not-taken guesses
    for (int k = 0; k < 5; k++) step(1, 4, 0, 0, 0, 0, 0, "R4");
    // R6 R7: train branch at pc 8 taken; local counter climbs and saturates
    for (int k = 0; k < 12; k++) step(0, 8, 1, 8, 1, 0, 0, "R7");
    step(0, 8, 0, 0, 0, 0, 0, "R7");
    for (int k = 0; k < 12; k++) step(0, 8, 1, 8, 0, 0, 0, "R7");
    // R6: alternating outcomes at pc 12 build a pattern, then lookups follow it
    for (int k = 0; k < 16; k++) step(0, 12, 1, 12, k[0], 0, 0, "R6");
    step(1, 12, 0, 0, 0, 0, 0, "R6");
    // R8 R9: global right, local wrong at history 5, choice learns global
    for (int k = 0; k < 6; k++) step(0, 16, 1, 20, 1, 0, 5, "R8");
    for (int k = 0; k < 6; k++) step(0, 16, 1, 24, 0, 1, 5, "R9");
    step(0, 0, 1, 0, 1, 1, 5, "R5");
    step(0, 28, 0, 0, 0, 0, 0, "R9");
    // R5: mispredict repair overrides a same-cycle lookup
    step(1, 4, 1, 4, 1, 1, 9, "R5");
    step(1, 4, 1, 4, 0, 1, 15, "R5");
    step(0, 4, 0, 0, 0, 0, 0, "R5");
    // R10: resolve without mispredict keeps history
    step(0, 4, 1, 4, 1, 0, 3, "R10");
    step(0, 4, 1, 8, 0, 0, 7, "R10");
    step(0, 4, 0, 0, 0, 0, 0, "R10");
    // R11: lookup and resolve of the same pc in one cycle
    for (int k = 0; k < 10; k++) step(1, 32, 1, 32, 1, k[2], k % 16, "R11");
    // R2: pseudo-random sweep against the model
    lf = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], int'(lf[4:2]) * 4, lf[5], int'(lf[8:6]) * 4, lf[9], lf[10] & lf[11],
           lf[12] ? int'(lf[15:12]) : m_gh, "R2");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule